// File: doc/BRIEF.md
# Buffered Input Capture Timer

This block timestamps signal transitions. A free-running 16-bit counter advances once every N bus cycles, where N is set by a 7-bit prescale value. Each of four capture inputs is synchronised and then passed through a per-channel delay filter. An edge that survives the filter and matches the channel's selected polarity copies the counter into that channel's capture register and raises the channel's flag.

A second 16-bit counter counts down under its own 4-bit prescaler and reloads from a programmable load value. Each reload is a periodic event that raises its own flag. In the same cycle it copies every capture register into a hold register behind it. Software can therefore read a consistent snapshot of all four channels while new captures keep arriving. All configuration and readback go through a single-cycle register port. The flags are cleared by writing ones to them and are combined with enable bits into one interrupt line.

Top module: `buf_capture_timer`

## Requirements
- R1: After reset, every register reads zero, all flags are clear and `irq` is low.
- R2: With the run bit (control register at address 0, bit 0) set, the main counter increments by one once every PRE+1 bus cycles, where PRE is control bits [14:8]. Writing address 7 loads the counter and restarts the prescaler. The counter value can be read back at address 7.
- R3: When the main counter steps from all ones to zero, flag bit 4 is set in that same cycle.
- R4: Channel i uses bits [2i+1:2i] of the edge register at address 3 to choose its polarity: bit 0 enables rising edges and bit 1 enables falling edges, so 00 disables the channel. An accepted edge stores the main counter in the capture register at address 16+i and sets flag bit i.
- R5: Channel i takes a 4-bit delay D from bits [4i+3:4i] of address 4. A new input level is accepted only after it has held for D+1 consecutive cycles. A pulse lasting D cycles or fewer sets no flag and leaves the capture register unchanged.
- R6: With the main prescale at zero, the same input edge captured through delay D reads exactly D counts higher than through delay 0.
- R7: With the modulus run bit (control bit 1) set, the modulus counter decrements once every M+1 cycles, where M is the 4-bit value at address 1. On a step taken at zero it reloads from the load register at address 2 and sets flag bit 5. Writing address 2 loads both the load register and the counter and restarts the modulus prescaler. Events therefore occur every (L+1)(M+1) cycles.
- R8: Each modulus reload copies every capture register into its hold register at address 24+i. Captures between reloads leave the hold registers unchanged.
- R9: Writing the flag register at address 5 clears each flag whose written bit is 1 and leaves flags whose written bit is 0 untouched.
- R10: `irq` is high exactly when some flag is set whose enable bit is set in the register at address 6, which uses the same bit positions as the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| cap_in | input | 4 | Capture inputs |
| flags | output | 6 | Flags: [3:0] channel captures, [4] counter wrap, [5] modulus event |
| irq | output | 1 | Interrupt request |

## Verification
Polarity is checked by driving random 2-bit edge codes on all channels at once, then raising and lowering the inputs together. This separates the rising, falling, both and off decodes. The filter is driven with random delays and single pulses exactly D and D+1 cycles long, which pins the acceptance boundary to within one cycle. Two channels fed by one edge with different delays show that the filter delay appears in the timestamp. Random modulus prescale and load values are used to check that the reload and the snapshot copy land on the predicted cycle, and not one cycle before it.

// File: rtl/buf_capture_timer.sv
module buf_capture_timer #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 7,
  parameter int MPW = 4,
  parameter int DLW = 4,
  parameter int AW  = 5
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH+1:0] flags,
  output logic           irq
);
  localparam int NF = NCH + 2;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_MPRE  = AW'(1);
  localparam logic [AW-1:0] A_MLOAD = AW'(2);
  localparam logic [AW-1:0] A_EDGE  = AW'(3);
  localparam logic [AW-1:0] A_DLY   = AW'(4);
  localparam logic [AW-1:0] A_FLAG  = AW'(5);
  localparam logic [AW-1:0] A_IEN   = AW'(6);
  localparam logic [AW-1:0] A_CNT   = AW'(7);
  localparam logic [AW-1:0] A_MCNT  = AW'(8);
  localparam logic [AW-1:0] A_CAP   = AW'(16);
  localparam logic [AW-1:0] A_HOLD  = AW'(24);

  logic               run, mrun;
  logic [PW-1:0]      pre, pcnt;
  logic [MPW-1:0]     mpre, mpcnt;
  logic [CW-1:0]      cnt, mload, mcnt;
  logic [2*NCH-1:0]   edge_sel;
  logic [DLW*NCH-1:0] dly;
  logic [NF-1:0]      ien;
  logic [NCH-1:0]     hit;
  logic [NCH*CW-1:0]  cap_all, hold_all;

  wire tick   = run && pcnt == pre;
  wire mtick  = mrun && mpcnt == mpre;
  wire wr_cnt = wr_en && addr == A_CNT;
  wire wr_ml  = wr_en && addr == A_MLOAD;
  wire wrap   = tick && !wr_cnt && (&cnt);
  wire reload = mtick && !wr_ml && mcnt == '0;

  wire [NF-1:0] set_v = {reload, wrap, hit};
  wire [NF-1:0] clr_v = (wr_en && addr == A_FLAG) ? wdata[NF-1:0] : '0;

  assign irq = |(flags & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; mrun <= 1'b0; pre <= '0; pcnt <= '0;
      mpre <= '0; mpcnt <= '0; cnt <= '0; mload <= '0; mcnt <= '0;
      edge_sel <= '0; dly <= '0; ien <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            run  <= wdata[0];
            mrun <= wdata[1];
            pre  <= wdata[8 +: PW];
          end
          A_MPRE:  mpre     <= wdata[MPW-1:0];
          A_EDGE:  edge_sel <= wdata[2*NCH-1:0];
          A_DLY:   dly      <= wdata[DLW*NCH-1:0];
          A_IEN:   ien      <= wdata[NF-1:0];
          default: ;
        endcase
      end
      if (wr_cnt) begin
        cnt  <= wdata;
        pcnt <= '0;
      end else if (run) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
      end
      if (wr_ml) begin
        mload <= wdata;
        mcnt  <= wdata;
        mpcnt <= '0;
      end else if (mrun) begin
        mpcnt <= mtick ? '0 : mpcnt + 1'b1;
        if (mtick) mcnt <= (mcnt == '0) ? mload : mcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0]     sy;
    logic           lvl;
    logic [DLW-1:0] dc;
    logic [CW-1:0]  cap_r, hold_r;
    wire  [DLW-1:0] lim  = dly[i*DLW +: DLW];
    wire  [1:0]     es   = edge_sel[2*i +: 2];
    wire            flip = (sy[1] != lvl) && (dc >= lim);

    assign hit[i] = flip && (sy[1] ? es[0] : es[1]);
    assign cap_all[i*CW +: CW]  = cap_r;
    assign hold_all[i*CW +: CW] = hold_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy <= '0; lvl <= 1'b0; dc <= '0; cap_r <= '0; hold_r <= '0;
      end else begin
        sy <= {sy[0], cap_in[i]};
        if (sy[1] == lvl || flip) dc <= '0;
        else                      dc <= dc + 1'b1;
        if (flip)   lvl    <= sy[1];
        if (hit[i]) cap_r  <= cnt;
        if (reload) hold_r <= cap_r;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0]      = run;
        rdata[1]      = mrun;
        rdata[8 +: PW] = pre;
      end
      A_MPRE:  rdata[MPW-1:0]     = mpre;
      A_MLOAD: rdata              = mload;
      A_EDGE:  rdata[2*NCH-1:0]   = edge_sel;
      A_DLY:   rdata[DLW*NCH-1:0] = dly;
      A_FLAG:  rdata[NF-1:0]      = flags;
      A_IEN:   rdata[NF-1:0]      = ien;
      A_CNT:   rdata              = cnt;
      A_MCNT:  rdata              = mcnt;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addr == A_CAP + AW'(i))  rdata = cap_all[i*CW +: CW];
          if (addr == A_HOLD + AW'(i)) rdata = hold_all[i*CW +: CW];
        end
      end
    endcase
  end
endmodule

// File: rtl/buf_capture_timer_chk.sv
module buf_capture_timer_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cnt,
  input logic              wr_ml,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     mcnt,
  input logic [CW-1:0]     mload,
  input logic [NCH+1:0]    flags,
  input logic [NCH*CW-1:0] cap_all,
  input logic [NCH*CW-1:0] hold_all
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_cnt) |-> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1))); // R2

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[NCH]) |-> (&$past(cnt))); // R3

  AST_MCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ml) |-> (mcnt == $past(mcnt) || mcnt == $past(mcnt) - CW'(1)
                       || ($past(mcnt) == '0 && mcnt == mload))); // R7

  AST_HOLD_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_all) |-> (flags[NCH+1] && mcnt == mload)); // R8

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_all[i*CW +: CW]) |-> flags[i]); // R4
  end
endmodule

bind buf_capture_timer buf_capture_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ml(wr_ml),
  .cnt(cnt), .mcnt(mcnt), .mload(mload), .flags(flags),
  .cap_all(cap_all), .hold_all(hold_all)
);

// File: tb/buf_capture_timer_tb.sv
module buf_capture_timer_tb;
  localparam int NCH = 4, CW = 16, AW = 5;
  localparam int OVFB = NCH, MODB = NCH + 1;
  localparam int A_CTRL = 0, A_MPRE = 1, A_MLOAD = 2, A_EDGE = 3, A_DLY = 4,
                 A_FLAG = 5, A_IEN = 6, A_CNT = 7, A_MCNT = 8, A_CAP = 16, A_HOLD = 24;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0]  addr = '0;
  logic [CW-1:0]  wdata = '0, rdata;
  logic [NCH-1:0] cap_in = '0;
  logic [NCH+1:0] flags;
  logic irq;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  buf_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .flags(flags), .irq(irq));

  function automatic bit exp_hit(logic [1:0] es, bit rising);
    return rising ? es[0] : es[1];
  endfunction
  function automatic bit passes(int len, int d);
    return len > d;
  endfunction
  function automatic int mod_period(int l, int m);
    return (l + 1) * (m + 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = CW'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(int a, output int d);
    addr = AW'(a); #1; d = int'(rdata);
  endtask
  task automatic pulse(int c, int len);
    @(negedge clk); cap_in[c] = 1'b1;
    repeat (len) @(negedge clk);
    cap_in[c] = 1'b0;
  endtask
  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, v2, c, d, p, m, l, n;
    int capv [NCH];
    int holdv;
    logic [2*NCH-1:0] es;
    logic [NCH-1:0] expv;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
    rd(A_MCNT, v); check("R1 mcnt", v, 0);
    rd(A_CAP, v);  check("R1 cap0", v, 0);
    rd(A_HOLD, v); check("R1 hold0", v, 0);
    check("R1 flags", int'(flags), 0);
    check("R1 irq", int'(irq), 0);

    // R2 prescaled counting
    for (int t = 0; t < 3; t++) begin
      p = int'($urandom % 128);
      wr(A_CTRL, 1 | (p << 8));
      wr(A_CNT, 0);
      rd(A_CNT, v);
      repeat (3 * (p + 1)) @(negedge clk);
      rd(A_CNT, v2);
      check("R2 prescale step", (v2 - v) & 16'hFFFF, 3);
    end
    wr(A_CTRL, 1 | (5 << 8));
    wr(A_CNT, 16'h1234);
    rd(A_CNT, v); check("R2 counter load", v, 16'h1234);

    // R3 wrap flag
    wr(A_CTRL, 1);
    wr(A_FLAG, 16'h3F);
    wr(A_CNT, 16'hFFFD);
    repeat (2) @(negedge clk);
    check("R3 no flag before wrap", int'(flags[OVFB]), 0);
    @(negedge clk);
    check("R3 flag at wrap", int'(flags[OVFB]), 1);
    rd(A_CNT, v); check("R3 count wrapped", v, 0);

    // R4 polarity decode, random codes
    wr(A_DLY, 0);
    for (int t = 0; t < 5; t++) begin
      es = 8'($urandom);
      wr(A_EDGE, int'(es));
      wr(A_FLAG, 16'h3F);
      @(negedge clk); cap_in = '1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < NCH; i++) expv[i] = exp_hit(es[2*i +: 2], 1'b1);
      check("R4 rising decode", int'(flags[NCH-1:0]), int'(expv));
      wr(A_FLAG, 16'h3F);
      @(negedge clk); cap_in = '0;
      repeat (10) @(negedge clk);
      for (int i = 0; i < NCH; i++) expv[i] = exp_hit(es[2*i +: 2], 1'b0);
      check("R4 falling decode", int'(flags[NCH-1:0]), int'(expv));
    end

    // R5 filter boundary, random delays
    wr(A_EDGE, 16'h55);
    for (int t = 0; t < 6; t++) begin
      c = int'($urandom % NCH);
      d = int'($urandom % 16);
      wr(A_DLY, d << (4 * c));
      wr(A_FLAG, 16'h3F);
      rd(A_CAP + c, v);
      if (d > 0) begin
        pulse(c, d);
        repeat (30) @(negedge clk);
        check("R5 short pulse flag", int'(flags[c]), int'(passes(d, d)));
        rd(A_CAP + c, v2); check("R5 short pulse capture kept", v2, v);
      end
      pulse(c, d + 1);
      repeat (40) @(negedge clk);
      check("R5 long pulse flag", int'(flags[c]), int'(passes(d + 1, d)));
    end

    // R6 delay appears in timestamp
    wr(A_EDGE, 16'h05);
    for (int t = 0; t < 3; t++) begin
      d = 1 + int'($urandom % 15);
      wr(A_DLY, d << 4);
      @(negedge clk); cap_in[1:0] = 2'b11;
      repeat (40) @(negedge clk);
      rd(A_CAP, v); rd(A_CAP + 1, v2);
      check("R6 delay offset", (v2 - v) & 16'hFFFF, d);
      cap_in[1:0] = 2'b00;
      repeat (40) @(negedge clk);
    end

    // R9 write-one-to-clear, R10 irq gating
    wr(A_EDGE, 16'hFF);
    wr(A_DLY, 0);
    wr(A_FLAG, 16'h3F);
    @(negedge clk); cap_in = '1;
    repeat (10) @(negedge clk);
    check("R9 all channel flags set", int'(flags[NCH-1:0]), 4'hF);
    wr(A_FLAG, 0);
    check("R9 zero write keeps flags", int'(flags[NCH-1:0]), 4'hF);
    wr(A_FLAG, 4'b0101);
    check("R9 ones clear selected", int'(flags[NCH-1:0]), 4'b1010);
    wr(A_IEN, 0);
    check("R10 irq masked", int'(irq), 0);
    wr(A_IEN, 4'b0010);
    check("R10 irq enabled flag", int'(irq), 1);
    wr(A_IEN, 4'b0001);
    check("R10 irq enabled on clear flag", int'(irq), 0);
    wr(A_IEN, 0);
    @(negedge clk); cap_in = '0;
    repeat (10) @(negedge clk);
    wr(A_FLAG, 16'h3F);

    // R7 modulus event timing, R8 snapshot
    for (int t = 0; t < 3; t++) begin
      m = int'($urandom % 16);
      l = int'($urandom % 21);
      n = mod_period(l, m);
      wr(A_CTRL, 1);
      wr(A_MPRE, m);
      wr(A_MLOAD, l);
      wr(A_FLAG, 1 << MODB);
      for (int i = 0; i < NCH; i++) rd(A_CAP + i, capv[i]);
      wr(A_CTRL, 3);
      repeat (n - 1) @(negedge clk);
      check("R7 no event early", int'(flags[MODB]), 0);
      @(negedge clk);
      check("R7 event on time", int'(flags[MODB]), 1);
      rd(A_MCNT, v); check("R7 reload value", v, l);
      for (int i = 0; i < NCH; i++) begin
        rd(A_HOLD + i, v);
        check("R8 hold copy", v, capv[i]);
      end
      wr(A_CTRL, 1);
    end
    rd(A_HOLD, holdv);
    rd(A_CAP, v);
    wr(A_EDGE, 16'h01);
    @(negedge clk); cap_in[0] = 1'b1;
    repeat (10) @(negedge clk);
    rd(A_CAP, v2);
    check("R8 new capture differs", int'(v2 != v), 1);
    rd(A_HOLD, v); check("R8 hold unchanged by capture", v, holdv);
    cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule